// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block handles the PAR line of a 32-bit PCI agent. In every clock where the agent owns the AD lines, it folds the outgoing address or data word and the command or byte-enable nibble into one even-parity bit. It drives that bit, with its own output enable, on the following clock. It does this during address phases, data phases and bus parking alike. The PAR enable always trails the AD enable by exactly one clock, whether the agent starts or stops driving.

When another agent sources the bus, the block tracks FRAME#, IRDY# and TRDY# to find each address phase and each data phase that actually carries data. It takes the parity of the received word in that clock and compares it with the PAR value that arrives one clock later. A mismatch raises a one-clock pulse on a separate flag for address phases and for data phases. Phase decoding handles dual-address cycles, wait states and back-to-back transfers. The surrounding bus interface logic uses the enables to steer its PAR pad and turns the error pulses into its own error signalling.

Top module: `pci_parity_unit`

## Requirements
- R1: While `par_oe` is high, `par_out` makes the total count of ones across `par_out` and the `ad_out`/`cbe_out` values of the previous clock even (36 covered bits).
- R2: `par_oe` equals the value `ad_oe` had one clock earlier, in both the enable and the release direction, including idle cycles with the bus parked.
- R3: An address phase is the first clock with `frame_n` low after a clock with `frame_n` high. If `ad_oe` is low in that clock and the `par_in` of the next clock does not give even parity, `addr_perr` pulses in the clock after that. `addr_perr` and `data_perr` are never high together.
- R4: An address phase whose `cbe_in` equals 4'b1101 is followed by a second address phase, which is checked the same way. The bus command is taken from the last address phase.
- R5: A data phase carries valid data when the command has bit 0 set (write) and `irdy_n` is low, or when bit 0 is clear (read) and `trdy_n` is low. A parity mismatch on such a phase pulses `data_perr` two clocks after the phase.
- R6: Wait-state clocks, where the ready signal named in R5 is high, are not checked; a wrong `par_in` in the clock that follows them raises no flag.
- R7: No phase in which `ad_oe` is high is checked, whatever `par_in` does one clock later.
- R8: Consecutive bad phases give one flag pulse per phase, so the flag stays high on consecutive clocks.
- R9: After synchronous reset (`rst` high), `par_oe`, `addr_perr` and `data_perr` are low.
- R10: A transaction ends after a clock with `frame_n` high and either `irdy_n` high or both ready signals low. Until the next address phase, no data check is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Sampled FRAME#, low active |
| irdy_n | input | 1 | Sampled IRDY#, low active |
| trdy_n | input | 1 | Sampled TRDY#, low active |
| ad_in | input | 32 | Address/data value seen on the bus |
| cbe_in | input | 4 | Command/byte-enable value seen on the bus |
| par_in | input | 1 | PAR value seen on the bus |
| ad_oe | input | 1 | This agent drives AD and C/BE# in the current clock |
| ad_out | input | 32 | Address/data value this agent drives |
| cbe_out | input | 4 | Command/byte-enable value this agent drives |
| par_out | output | 1 | Generated parity for the PAR pad |
| par_oe | output | 1 | Output enable for the PAR pad |
| addr_perr | output | 1 | One-clock pulse: address phase parity error |
| data_perr | output | 1 | One-clock pulse: data phase parity error |

## Verification
The generated `par_out` and `par_oe` belong to the clock after the one whose `ad_out`, `cbe_out` and `ad_oe` produced them. An error flag belongs to the clock after the one that carried the matching `par_in`, which is two clocks after the sampled phase. The driver computes, in every clock, the expected enable and parity for the next clock together with the error verdict for the phase held from the previous clock. It queues them as one item stamped with the clock in which they are due. The monitor compares outputs on the falling edge, away from the edge at which inputs change, and it compares only when an item's due stamp matches the current clock count, so each result is checked in exactly the clock where it must appear.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // Kind of phase the checker should verify in a given clock
    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Command that announces a second address phase
    localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;

    // Commands with bit 0 set move data from initiator to target
    function automatic logic cmd_is_write(input logic [3:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drv_oe,
    input  logic [DW-1:0] drv_ad,
    input  logic [BW-1:0] drv_cbe,
    output logic          par_o,
    output logic          par_oe_o
);

    logic par_q;
    logic oe_q;

    // Parity of the driven value is always registered; the enable trails AD's by one clock
    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            par_q <= ^{drv_ad, drv_cbe};
            oe_q  <= drv_oe;
        end
    end

    assign par_o    = par_q;
    assign par_oe_o = oe_q;

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && par_oe_o) |-> ((^{par_o, $past(drv_ad), $past(drv_cbe)}) == 1'b0)); // R1

    AST_PAR_OE_ON: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_oe) |=> par_oe_o); // R2

    AST_PAR_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_oe) |=> !par_oe_o); // R2

endmodule

// File: rtl/pci_phase_track.sv
module pci_phase_track
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       trdy_n,
    input  logic [3:0] cmd_in,
    output phase_e     phase_o
);

    logic       frame_q;
    logic       dual_q;
    logic       in_data_q;
    logic [3:0] cmd_q;

    logic addr_first;
    logic addr_ph;
    logic addr_last;
    logic xfer_end;
    logic data_ok;

    // R3: start of a transaction is a falling FRAME#
    assign addr_first = !frame_n && frame_q;
    // R4: a dual-address command adds a second address phase
    assign addr_ph    = addr_first || dual_q;
    assign addr_last  = addr_ph && !(addr_first && (cmd_in == CMD_DUAL_ADDR));
    // R10: last transfer done or bus idle
    assign xfer_end   = frame_n && (irdy_n || !trdy_n);
    // R5/R6: the ready signal of the data source marks valid data
    assign data_ok    = in_data_q && !addr_ph &&
                        (cmd_is_write(cmd_q) ? !irdy_n : !trdy_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= 1'b1;
            dual_q    <= 1'b0;
            in_data_q <= 1'b0;
            cmd_q     <= 4'h0;
        end else begin
            frame_q <= frame_n;
            dual_q  <= addr_first && (cmd_in == CMD_DUAL_ADDR);
            if (addr_ph) begin
                cmd_q <= cmd_in;
            end
            if (addr_last) begin
                in_data_q <= 1'b1;
            end else if (xfer_end) begin
                in_data_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (addr_ph) begin
            phase_o = PH_ADDR;
        end else if (data_ok) begin
            phase_o = PH_DATA;
        end else begin
            phase_o = PH_NONE;
        end
    end

    AST_NO_DATA_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_n) && $past(irdy_n) && frame_n) |-> (phase_o != PH_DATA)); // R10

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
    import pci_par_pkg::*;
#(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase_i,
    input  logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    input  logic [BW-1:0] cbe_in,
    input  logic          par_in,
    output logic          addr_perr,
    output logic          data_perr
);

    phase_e kind_q;
    logic   sum_q;
    logic   mism;
    logic   aerr_q;
    logic   derr_q;

    // Only the reduced parity of the sampled phase is kept, not the 36 bits
    assign mism = sum_q ^ par_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= PH_NONE;
            sum_q  <= 1'b0;
            aerr_q <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            aerr_q <= (kind_q == PH_ADDR) && mism;
            derr_q <= (kind_q == PH_DATA) && mism;
            kind_q <= ad_oe ? PH_NONE : phase_i; // R7
            sum_q  <= ^{ad_in, cbe_in};
        end
    end

    assign addr_perr = aerr_q;
    assign data_perr = derr_q;

    AST_ERR_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(addr_perr && data_perr)); // R3

    AST_NO_SELF_CHECK: assert property (@(posedge clk) disable iff (rst)
        (addr_perr || data_perr) |-> !$past(ad_oe, 2)); // R7

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic          trdy_n,
    input  logic [DW-1:0] ad_in,
    input  logic [BW-1:0] cbe_in,
    input  logic          par_in,
    input  logic          ad_oe,
    input  logic [DW-1:0] ad_out,
    input  logic [BW-1:0] cbe_out,
    output logic          par_out,
    output logic          par_oe,
    output logic          addr_perr,
    output logic          data_perr
);

    phase_e phase;

    pci_par_gen #(.DW(DW), .BW(BW)) i_gen (
        .clk      (clk),
        .rst      (rst),
        .drv_oe   (ad_oe),
        .drv_ad   (ad_out),
        .drv_cbe  (cbe_out),
        .par_o    (par_out),
        .par_oe_o (par_oe)
    );

    pci_phase_track i_track (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .cmd_in  (cbe_in[3:0]),
        .phase_o (phase)
    );

    pci_par_check #(.DW(DW), .BW(BW)) i_chk (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase),
        .ad_oe     (ad_oe),
        .ad_in     (ad_in),
        .cbe_in    (cbe_in),
        .par_in    (par_in),
        .addr_perr (addr_perr),
        .data_perr (data_perr)
    );

endmodule

// File: tb/test_pci_parity_unit.sv
module test_pci_parity_unit;
    import pci_par_pkg::*;

    typedef struct packed {
        int          due;
        logic        oe;
        logic        par;
        logic        ea;
        logic        ed;
        logic [31:0] tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        par_in = 1'b0;
    logic        ad_oe = 1'b0;
    logic [31:0] ad_out = '0;
    logic [3:0]  cbe_out = '0;
    logic        par_out;
    logic        par_oe;
    logic        addr_perr;
    logic        data_perr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    exp_t sb[$];
    exp_t it;

    logic [31:0] prev_ad = '0;
    logic [3:0]  prev_cbe = '0;
    phase_e      pend_k = PH_NONE;
    logic        pend_bad = 1'b0;
    logic [31:0] pend_tag = "R9";

    pci_parity_unit i_pci_parity_unit (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .ad_in     (ad_in),
        .cbe_in    (cbe_in),
        .par_in    (par_in),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out),
        .cbe_out   (cbe_out),
        .par_out   (par_out),
        .par_oe    (par_oe),
        .addr_perr (addr_perr),
        .data_perr (data_perr)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at clock %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
        end
    endtask

    // Driver: applies one bus clock and queues what is due one clock later
    task automatic drive(input logic f, input logic i, input logic t, input logic oe,
                         input logic [31:0] ad, input logic [3:0] cbe,
                         input phase_e k, input logic bad, input logic [31:0] tag);
        exp_t e;
        @(posedge clk);
        #1;
        cyc++;
        frame_n = f;
        irdy_n  = i;
        trdy_n  = t;
        ad_oe   = oe;
        ad_in   = ad;
        ad_out  = ad;
        cbe_in  = cbe;
        cbe_out = cbe;
        par_in  = (^{prev_ad, prev_cbe}) ^ pend_bad;
        e.due = cyc + 1;
        e.oe  = oe;
        e.par = ^{ad, cbe};
        e.ea  = (pend_k == PH_ADDR) && pend_bad;
        e.ed  = (pend_k == PH_DATA) && pend_bad;
        e.tag = pend_tag;
        sb.push_back(e);
        prev_ad  = ad;
        prev_cbe = cbe;
        pend_k   = oe ? PH_NONE : k;
        pend_bad = bad;
        pend_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 4'h0, PH_NONE, 1'b0, "R10");
        end
    endtask

    // Monitor: compares on the falling edge the items due in this clock
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                it = sb.pop_front();
                if (it.due == cyc) begin
                    check("R2", "par_oe", par_oe, it.oe);
                    if (it.oe) begin
                        check("R1", "par_out", par_out, it.par);
                    end
                    check(it.tag, "addr_perr", addr_perr, it.ea);
                    check(it.tag, "data_perr", data_perr, it.ed);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", "par_oe in reset", par_oe, 1'b0);
        check("R9", "addr_perr in reset", addr_perr, 1'b0);
        check("R9", "data_perr in reset", data_perr, 1'b0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        idle(2);

        // R2/R1: bus parked by this agent, then released
        drive(1, 1, 1, 1, 32'hA5A5_0F0F, 4'h3, PH_NONE, 1'b0, "R2");
        drive(1, 1, 1, 1, 32'hA5A5_0F0F, 4'h3, PH_NONE, 1'b0, "R2");
        drive(1, 1, 1, 1, 32'h0000_0001, 4'h0, PH_NONE, 1'b0, "R1");
        drive(1, 1, 1, 1, 32'hFFFF_FFFF, 4'h7, PH_NONE, 1'b0, "R1");
        drive(1, 1, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b0, "R2");
        idle(2);

        // Incoming write: good address, wait state, data phases, back-to-back errors
        drive(0, 1, 1, 0, 32'h1000_0040, 4'b0111, PH_ADDR, 1'b0, "R3");
        drive(0, 1, 1, 0, 32'h1234_5678, 4'h0, PH_NONE, 1'b1, "R6");
        drive(0, 0, 1, 0, 32'h1234_5678, 4'h0, PH_DATA, 1'b0, "R5");
        drive(0, 0, 0, 0, 32'h1234_5678, 4'h0, PH_DATA, 1'b1, "R5");
        drive(1, 0, 0, 0, 32'h9ABC_DEF0, 4'h3, PH_DATA, 1'b1, "R8");
        drive(1, 1, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b0, "R10");
        drive(1, 0, 0, 0, 32'h0000_0007, 4'h0, PH_NONE, 1'b1, "R10");
        idle(2);

        // Incoming read, bad address; this agent is target and drives data
        drive(0, 1, 1, 0, 32'h2000_0000, 4'b0110, PH_ADDR, 1'b1, "R3");
        drive(0, 0, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b0, "R6");
        drive(0, 0, 0, 1, 32'hCAFE_0001, 4'h0, PH_DATA, 1'b1, "R7");
        drive(1, 0, 0, 1, 32'hCAFE_0002, 4'h0, PH_DATA, 1'b1, "R7");
        drive(1, 1, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b0, "R2");
        idle(2);

        // This agent initiates a read: own address unchecked, target data checked
        drive(0, 1, 1, 1, 32'h3000_0010, 4'b0110, PH_ADDR, 1'b1, "R7");
        drive(0, 0, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b1, "R6");
        drive(0, 0, 0, 0, 32'h0BAD_0BAD, 4'h0, PH_DATA, 1'b1, "R5");
        drive(0, 0, 1, 0, 32'h0BAD_0BAD, 4'h0, PH_NONE, 1'b1, "R6");
        drive(1, 0, 0, 0, 32'h5555_AAAA, 4'h0, PH_DATA, 1'b0, "R5");
        idle(2);

        // Dual-address cycle: both address phases bad, read command from second phase
        drive(0, 1, 1, 0, 32'h4000_0000, 4'b1101, PH_ADDR, 1'b1, "R4");
        drive(0, 1, 1, 0, 32'h0000_0001, 4'b0110, PH_ADDR, 1'b1, "R8");
        drive(0, 0, 1, 0, 32'h0, 4'h0, PH_NONE, 1'b1, "R4");
        drive(1, 0, 0, 0, 32'h7777_0000, 4'hF, PH_DATA, 1'b1, "R4");
        idle(4);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule